// File: doc/BRIEF.md
# Dual-Compare PWM Generator

This block produces a pulse-width-modulated waveform from a 16-bit up-counter and two 16-bit compare values. The counter advances once per count tick. A prescaler derives that tick from the base clock by one of seven power-of-two divisions, from /2 up to /128. The first compare value sets the length of the period. The second sets how long the output stays at its active level. The output is held in a set/reset latch: a match on the first compare value sets it and a match on the second clears it. A polarity input chooses whether the active level is high or low.

Two inputs gate the function. `tmr_enable` starts the timer. `timer_mode` must be 0, the general-purpose timer mode, for the PWM to run. While the timer is not running, the counter rests at zero and the output sits at its inactive level. The compare values are written through a simple write port into shadow registers. A new value reaches the comparators only when the counter clears at the end of a period, so a period already in progress is never cut short or stretched. Each compare match also raises its own one-cycle interrupt pulse.

Top module: `pwm_dual_cmp`

## Requirements
- R1: When `tmr_enable` is 0 or `timer_mode` is 1, the counter holds at zero, no interrupt pulse is raised, and `pwm_out` equals `out_polarity`, which is the inactive level.
- R2: `presc_sel` values 0 to 6 produce one count tick every 2, 4, 8, 16, 32, 64 or 128 base clock cycles. The value 7 produces the same rate as 6, one tick every 128 cycles.
- R3: On each tick the counter increments. On the tick where it equals the active first compare value CM0, it returns to zero instead. One period therefore lasts (CM0+1) ticks.
- R4: A CM0 match sets the output latch and a CM1 match clears it. When both match on the same tick, clearing wins. Per period the output is active for (CM1+1) ticks if CM1 < CM0, never if CM1 = CM0, and for the whole period if CM1 > CM0.
- R5: With `out_polarity` = 0 the active level is 1. With `out_polarity` = 1 the active level is 0.
- R6: A CM0 match raises `irq_cm0` and a CM1 match raises `irq_cm1`. Each pulse lasts one base clock cycle and starts in the cycle after the clock edge that carries the matching tick. The output latch changes on that same edge.
- R7: A write with `wr_cm0` or `wr_cm1` high stores `wr_data` in a shadow register. The comparators take the shadow value when the counter clears, or at any time while the timer is not running. A period that is already in progress keeps its old length.
- R8: After the timer starts, the first `irq_cm0` pulse appears (CM0+1)·D cycles later, where D is the division selected by `presc_sel`.
- R9: After reset the counter is zero, the latch is clear, and both interrupt outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmr_enable | input | 1 | Starts the timer when 1 |
| timer_mode | input | 1 | 0 selects general-purpose mode, in which PWM runs; 1 stops PWM |
| out_polarity | input | 1 | 0: active level high; 1: active level low |
| presc_sel | input | 3 | Prescale code; 0..6 gives /2../128, 7 gives /128 |
| wr_cm0 | input | 1 | Write strobe for the first compare shadow register |
| wr_cm1 | input | 1 | Write strobe for the second compare shadow register |
| wr_data | input | 16 | Compare value to be written |
| irq_cm0 | output | 1 | One-cycle pulse on a first-compare match |
| irq_cm1 | output | 1 | One-cycle pulse on a second-compare match |
| pwm_out | output | 1 | PWM waveform |

## Verification
Two situations are the hardest to reach from the ports. The first is a compare write that lands in the middle of a running period. The bench writes a new CM0 in the cycle right after an `irq_cm0` pulse. It then checks that the current period keeps its old length and that only the next period takes the new one. The second is a same-tick collision of set and clear, when CM0 equals CM1. The bench sweeps all eight prescale codes and both polarities over compare pairs below, equal to and above each other. For each case it measures the start-up latency, the period, the active time and the CM1 pulse count in cycles, and compares them with values computed from D and the compare values.

// File: rtl/pwm_dual_cmp_pkg.sv
package pwm_dual_cmp_pkg;

  // Action applied to the output latch on a given cycle
  typedef enum logic [1:0] {
    LAT_HOLD = 2'd0,
    LAT_SET  = 2'd1,
    LAT_CLR  = 2'd2
  } lat_act_e;

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int NUM_TAPS = 7,
  parameter int SEL_W    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);

  localparam logic [SEL_W-1:0] MAX_SEL = SEL_W'(NUM_TAPS - 1);

  logic [NUM_TAPS-1:0] div_q;
  logic [NUM_TAPS-1:0] div_d;
  logic [NUM_TAPS-1:0] tap_hit;
  logic [SEL_W-1:0]    eff_sel;

  // Tap g fires once every 2^(g+1) cycles
  for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
    assign tap_hit[g] = &div_q[g:0];
  end

  always_comb begin
    eff_sel = (sel > MAX_SEL) ? MAX_SEL : sel;
    tick    = run && tap_hit[eff_sel];
    div_d   = run ? div_q + 1'b1 : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
    end else begin
      div_q <= div_d;
    end
  end

  // The smallest division is 2, so two ticks never arrive back to back
  p_tick_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             wr_cm0,
  input  logic             wr_cm1,
  input  logic [CNT_W-1:0] wr_data,
  output logic             hit0,
  output logic             hit1,
  output logic             irq0,
  output logic             irq1
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] sh0_q, sh0_d, sh1_q, sh1_d;
  logic [CNT_W-1:0] cm0_q, cm0_d, cm1_q, cm1_d;
  logic             load;

  always_comb begin
    hit0  = tick && (cnt_q == cm0_q);
    hit1  = tick && (cnt_q == cm1_q);
    cnt_d = cnt_q;
    if (!run) begin
      cnt_d = '0;
    end else if (tick) begin
      cnt_d = hit0 ? '0 : cnt_q + 1'b1;
    end
    sh0_d = wr_cm0 ? wr_data : sh0_q;
    sh1_d = wr_cm1 ? wr_data : sh1_q;
    load  = !run || hit0;
    cm0_d = load ? sh0_q : cm0_q;
    cm1_d = load ? sh1_q : cm1_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sh0_q <= '0;
      sh1_q <= '0;
      cm0_q <= '0;
      cm1_q <= '0;
      irq0  <= 1'b0;
      irq1  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      sh0_q <= sh0_d;
      sh1_q <= sh1_d;
      cm0_q <= cm0_d;
      cm1_q <= cm1_d;
      irq0  <= hit0;
      irq1  <= hit1;
    end
  end

  p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && !hit0) |=> (cnt_q == $past(cnt_q) + 1'b1));

  p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= cm0_q));

  p_buffer_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !hit0) |=> ($stable(cm0_q) && $stable(cm1_q)));

  p_irq_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq0 |=> !irq0);

endmodule

// File: rtl/pwm_out_latch.sv
module pwm_out_latch
  import pwm_dual_cmp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic set_i,
  input  logic clr_i,
  input  logic polarity,
  output logic pwm_out
);

  lat_act_e act;
  logic     lat_q, lat_d;

  always_comb begin
    if (clr_i)      act = LAT_CLR;
    else if (set_i) act = LAT_SET;
    else            act = LAT_HOLD;
    case (act)
      LAT_SET: lat_d = 1'b1;
      LAT_CLR: lat_d = 1'b0;
      default: lat_d = lat_q;
    endcase
    if (!run) lat_d = 1'b0;
    pwm_out = lat_q ^ polarity;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= 1'b0;
    end else begin
      lat_q <= lat_d;
    end
  end

  p_clear_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && clr_i) |=> !lat_q);

  p_idle_inactive_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !lat_q);

endmodule

// File: rtl/pwm_dual_cmp.sv
module pwm_dual_cmp #(
  parameter int CNT_W    = 16,
  parameter int NUM_TAPS = 7,
  parameter int SEL_W    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tmr_enable,
  input  logic             timer_mode,
  input  logic             out_polarity,
  input  logic [SEL_W-1:0] presc_sel,
  input  logic             wr_cm0,
  input  logic             wr_cm1,
  input  logic [CNT_W-1:0] wr_data,
  output logic             irq_cm0,
  output logic             irq_cm1,
  output logic             pwm_out
);

  logic run;
  logic tick;
  logic hit0, hit1;

  assign run = tmr_enable && !timer_mode;

  pwm_prescaler #(.NUM_TAPS(NUM_TAPS), .SEL_W(SEL_W)) u_presc (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run),
    .sel  (presc_sel),
    .tick (tick)
  );

  pwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run),
    .tick   (tick),
    .wr_cm0 (wr_cm0),
    .wr_cm1 (wr_cm1),
    .wr_data(wr_data),
    .hit0   (hit0),
    .hit1   (hit1),
    .irq0   (irq_cm0),
    .irq1   (irq_cm1)
  );

  pwm_out_latch u_lat (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .set_i   (hit0),
    .clr_i   (hit1),
    .polarity(out_polarity),
    .pwm_out (pwm_out)
  );

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!irq_cm0 && !irq_cm1));

endmodule

// File: tb/pwm_dual_cmp_bench.sv
`timescale 1ns/1ps
module pwm_dual_cmp_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tmr_enable = 1'b0;
  logic        timer_mode = 1'b0;
  logic        out_polarity = 1'b0;
  logic [2:0]  presc_sel = 3'd0;
  logic        wr_cm0 = 1'b0;
  logic        wr_cm1 = 1'b0;
  logic [15:0] wr_data = 16'd0;
  logic        irq_cm0, irq_cm1, pwm_out;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  pwm_dual_cmp u_pwm_dual_cmp (
    .clk(clk), .rst_n(rst_n), .tmr_enable(tmr_enable), .timer_mode(timer_mode),
    .out_polarity(out_polarity), .presc_sel(presc_sel), .wr_cm0(wr_cm0),
    .wr_cm1(wr_cm1), .wr_data(wr_data), .irq_cm0(irq_cm0), .irq_cm1(irq_cm1),
    .pwm_out(pwm_out)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int div_of(input int sel);
    return 2 << ((sel > 6) ? 6 : sel);
  endfunction

  task automatic write_cmp(input bit which, input int val);
    wr_data = 16'(val);
    wr_cm0  = !which;
    wr_cm1  = which;
    @(negedge clk);
    wr_cm0 = 1'b0;
    wr_cm1 = 1'b0;
  endtask

  // Samples until irq_cm0 is seen high; returns the number of samples taken
  task automatic wait_irq0(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!irq_cm0 && n < 5000);
  endtask

  task automatic run_cfg(input int cm0, input int cm1, input int sel, input bit pol);
    int d, lat, per, act, n1, exp_act;
    string tag;
    tag = $sformatf("cm0=%0d cm1=%0d sel=%0d pol=%0d", cm0, cm1, sel, pol);
    tmr_enable = 1'b0;
    timer_mode = 1'b0;
    presc_sel  = 3'(sel);
    out_polarity = pol;
    write_cmp(1'b0, cm0);
    write_cmp(1'b1, cm1);
    repeat (3) @(negedge clk);
    check(pwm_out == pol && !irq_cm0 && !irq_cm1, {"R1 idle level ", tag}, int'(pwm_out), int'(pol));
    d = div_of(sel);
    tmr_enable = 1'b1;
    wait_irq0(lat);
    check(lat == (cm0 + 1) * d, {"R8 R2 first match latency ", tag}, lat, (cm0 + 1) * d);
    // Steady-state period: samples from this pulse up to the next one
    act = (pwm_out != pol) ? 1 : 0;
    n1  = irq_cm1 ? 1 : 0;
    per = 1;
    forever begin
      @(negedge clk);
      if (irq_cm0 || per > 5000) break;
      per++;
      if (pwm_out != pol) act++;
      if (irq_cm1) n1++;
    end
    check(per == (cm0 + 1) * d, {"R3 R2 period ", tag}, per, (cm0 + 1) * d);
    if (cm1 < cm0)       exp_act = (cm1 + 1) * d;
    else if (cm1 == cm0) exp_act = 0;
    else                 exp_act = (cm0 + 1) * d;
    check(act == exp_act, {"R4 R5 active cycles ", tag}, act, exp_act);
    check(n1 == ((cm1 <= cm0) ? 1 : 0), {"R6 irq_cm1 pulses ", tag}, n1, (cm1 <= cm0) ? 1 : 0);
    tmr_enable = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    int n, quiet;
    repeat (3) @(negedge clk);
    // R9: reset state
    check(!irq_cm0 && !irq_cm1 && pwm_out == 1'b0, "R9 reset state", int'(pwm_out), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!irq_cm0 && !irq_cm1 && pwm_out == 1'b0, "R9 after release", int'(pwm_out), 0);

    // Sweep: all prescale codes, both polarities, compare pairs below/equal/above
    for (int s = 0; s < 8; s++) begin
      for (int p = 0; p < 2; p++) begin
        run_cfg(3, 1, s, p[0]);
        run_cfg(2, 2, s, p[0]);
        run_cfg(1, 4, s, p[0]);
        run_cfg(0, 0, s, p[0]);
        run_cfg(4, 0, s, p[0]);
      end
    end

    // R1: mode bit 1 keeps PWM stopped even with the enable set
    write_cmp(1'b0, 1);
    write_cmp(1'b1, 0);
    presc_sel = 3'd0;
    out_polarity = 1'b1;
    timer_mode = 1'b1;
    tmr_enable = 1'b1;
    quiet = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (irq_cm0 || irq_cm1 || pwm_out != 1'b1) quiet++;
    end
    check(quiet == 0, "R1 mode bit blocks PWM", quiet, 0);
    timer_mode = 1'b0;
    wait_irq0(n);
    check(n == 4, "R1 R8 start after mode cleared", n, 4);
    tmr_enable = 1'b0;
    @(negedge clk);

    // R7: a write in mid-period only affects the following period
    out_polarity = 1'b0;
    write_cmp(1'b0, 3);
    write_cmp(1'b1, 1);
    repeat (2) @(negedge clk);
    tmr_enable = 1'b1;
    wait_irq0(n);
    check(n == 8, "R7 initial period latency", n, 8);
    write_cmp(1'b0, 6);
    wait_irq0(n);
    check(n == 7, "R7 running period keeps old CM0", n + 1, 8);
    wait_irq0(n);
    check(n == 14, "R7 next period takes new CM0", n, 14);
    tmr_enable = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule